// File: doc/BRIEF.md
# Two-Pointer Victim Replacement Tracker

This block keeps the replacement state of a set-associative cache with only two pointers per set instead of a full recency order. One pointer names the victim way, the way that the next miss in that set overwrites. The other names the next victim, the way that takes over the victim role after the current victim leaves. Every other way of the set is ordinary and carries no state.

A cache controller reports each hit with its set and way, and each miss with its set. The block shows the victim of the missing set in the same cycle, so the fill logic knows which way to overwrite. At the next clock edge it moves the two pointers by fixed transition rules. Whenever a fresh next victim is needed, it is chosen among the ordinary ways by a shared linear feedback shift register. A separate lookup port shows both pointers of any chosen set.

The set count and the associativity are parameters. The associativity must be at least three, so that an ordinary way always exists.

Top module: `vnv_repl_tracker`

## Requirements
- R1: After a synchronous reset every set holds victim = way 0 and next victim = way 1.
- R2: In every set the victim and the next victim are two different ways, and both are below the associativity.
- R3: `miss_victim` shows the victim of `miss_set` combinationally. After a miss, the set's victim becomes its former next victim.
- R4: A new next victim is chosen like this. Start at way (L mod NUM_WAYS), where L is the current 8-bit register value. Step upward modulo NUM_WAYS past any way that is the current victim or the current next victim, and take the first way that is neither. The register starts at 0xA5. In every cycle with at least one pointer update, it shifts left by one, and its new bit 0 is the XOR of the old bits 7, 5, 4 and 3. A pick uses the value before that shift.
- R5: A hit to the victim way turns the former next victim into the victim and picks a new next victim per R4.
- R6: A hit to the next-victim way leaves the victim unchanged and picks a new next victim per R4.
- R7: A hit to an ordinary way changes no pointer and does not advance the register.
- R8: A hit and a miss to the same set in the same cycle act as the miss alone.
- R9: The way that leaves the victim or next-victim role (the replaced way on a miss, or the hit way) is never the new next victim, so it becomes ordinary.
- R10: A hit and a miss to different sets in the same cycle both take effect. Both picks use the same register value, and the register advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Hit strobe |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | WAY_W | Way of the hit |
| miss_valid | input | 1 | Miss/fill strobe |
| miss_set | input | SET_W | Set of the miss |
| miss_victim | output | WAY_W | Current victim of `miss_set` (way to overwrite) |
| lookup_set | input | SET_W | Set shown on the lookup outputs |
| victim_way | output | WAY_W | Victim of `lookup_set` |
| next_victim_way | output | WAY_W | Next victim of `lookup_set` |

## Verification
`miss_victim`, `victim_way` and `next_victim_way` are combinational reads of the pointer registers. They are due in the same cycle that their select input is applied. Pointer updates land at the clock edge that samples the strobe, so the new values are due one cycle after the strobe. The bench drives strobes just after a rising edge and reads `miss_victim` shortly before the sampling edge. It reads the pointers of a set just after the following edge, and it compares them against a model that computes the shift register and the pick rule from the requirements alone.

// File: rtl/vnv_pkg.sv
package vnv_pkg;

    localparam int SHREG_W = 8;
    localparam logic [SHREG_W-1:0] SHREG_SEED = 8'hA5;

    typedef logic [SHREG_W-1:0] shreg_t;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_MISS,
        EV_HIT_VIC,
        EV_HIT_NXT
    } set_event_e;

    function automatic shreg_t shreg_advance(input shreg_t cur);
        return {cur[SHREG_W-2:0], cur[7] ^ cur[5] ^ cur[4] ^ cur[3]};
    endfunction

endpackage

// File: rtl/vnv_shreg.sv
module vnv_shreg
    import vnv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output shreg_t value
);
    always_ff @(posedge clk) begin
        if (rst)       value <= SHREG_SEED;
        else if (step) value <= shreg_advance(value);
    end
endmodule

// File: rtl/vnv_pick.sv
module vnv_pick
    import vnv_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  shreg_t             seed_val,
    input  logic [WAY_W-1:0]   excl_a,
    input  logic [WAY_W-1:0]   excl_b,
    output logic [WAY_W-1:0]   chosen
);
    int start;
    int cand;
    logic found;

    always_comb begin
        start  = int'(seed_val) % NUM_WAYS;
        found  = 1'b0;
        chosen = '0;
        cand   = 0;
        for (int k = 0; k < 3; k++) begin
            cand = (start + k) % NUM_WAYS;
            if (!found && WAY_W'(cand) != excl_a && WAY_W'(cand) != excl_b) begin
                chosen = WAY_W'(cand);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vnv_set_entry.sv
module vnv_set_entry
    import vnv_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_here,
    input  logic             hit_here,
    input  logic [WAY_W-1:0] hit_way,
    input  shreg_t           seed_val,
    output logic [WAY_W-1:0] vic,
    output logic [WAY_W-1:0] nxt,
    output logic             changed
);
    typedef struct packed {
        logic [WAY_W-1:0] vic;
        logic [WAY_W-1:0] nxt;
    } ptr_pair_t;

    ptr_pair_t  cur;
    ptr_pair_t  upd;
    set_event_e ev;
    logic [WAY_W-1:0] fresh;

    vnv_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .seed_val (seed_val),
        .excl_a   (cur.vic),
        .excl_b   (cur.nxt),
        .chosen   (fresh)
    );

    always_comb begin
        if (miss_here)                    ev = EV_MISS;
        else if (hit_here && hit_way == cur.vic) ev = EV_HIT_VIC;
        else if (hit_here && hit_way == cur.nxt) ev = EV_HIT_NXT;
        else                              ev = EV_IDLE;
    end

    always_comb begin
        upd = cur;
        unique case (ev)
            EV_MISS, EV_HIT_VIC: begin
                upd.vic = cur.nxt;
                upd.nxt = fresh;
            end
            EV_HIT_NXT: upd.nxt = fresh;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.vic <= WAY_W'(0);
            cur.nxt <= WAY_W'(1);
        end else begin
            cur <= upd;
        end
    end

    assign vic     = cur.vic;
    assign nxt     = cur.nxt;
    assign changed = (ev != EV_IDLE);
endmodule

// File: rtl/vnv_repl_tracker.sv
module vnv_repl_tracker
    import vnv_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             miss_valid,
    input  logic [SET_W-1:0] miss_set,
    output logic [WAY_W-1:0] miss_victim,
    input  logic [SET_W-1:0] lookup_set,
    output logic [WAY_W-1:0] victim_way,
    output logic [WAY_W-1:0] next_victim_way
);
    logic [WAY_W-1:0]    vic_arr [NUM_SETS];
    logic [WAY_W-1:0]    nxt_arr [NUM_SETS];
    logic [NUM_SETS-1:0] set_changed;
    shreg_t              seed_val;

    vnv_shreg u_shreg (
        .clk   (clk),
        .rst   (rst),
        .step  (|set_changed),
        .value (seed_val)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic miss_here;
        logic hit_here;
        assign miss_here = miss_valid && (miss_set == SET_W'(s));
        assign hit_here  = hit_valid && (hit_set == SET_W'(s)) && !miss_here;

        vnv_set_entry #(.NUM_WAYS(NUM_WAYS)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .miss_here (miss_here),
            .hit_here  (hit_here),
            .hit_way   (hit_way),
            .seed_val  (seed_val),
            .vic       (vic_arr[s]),
            .nxt       (nxt_arr[s]),
            .changed   (set_changed[s])
        );
    end

    assign miss_victim     = vic_arr[miss_set];
    assign victim_way      = vic_arr[lookup_set];
    assign next_victim_way = nxt_arr[lookup_set];
endmodule

// File: rtl/vnv_tracker_checker.sv
module vnv_tracker_checker #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             hit_valid,
    input logic [SET_W-1:0] hit_set,
    input logic [WAY_W-1:0] hit_way,
    input logic             miss_valid,
    input logic [SET_W-1:0] miss_set,
    input logic [WAY_W-1:0] miss_victim,
    input logic [SET_W-1:0] lookup_set,
    input logic [WAY_W-1:0] victim_way,
    input logic [WAY_W-1:0] next_victim_way
);
    logic miss_on_lookup;
    logic hit_on_lookup;
    assign miss_on_lookup = miss_valid && (miss_set == lookup_set);
    assign hit_on_lookup  = hit_valid && (hit_set == lookup_set) && !miss_on_lookup;

    assert_ptrs_distinct_R2: assert property (@(posedge clk) disable iff (rst)
        victim_way != next_victim_way);

    assert_ptrs_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(victim_way) < NUM_WAYS) && (int'(next_victim_way) < NUM_WAYS));

    assert_miss_port_matches_R3: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_set == lookup_set) |-> miss_victim == victim_way);

    assert_miss_promotes_next_R3: assert property (@(posedge clk) disable iff (rst)
        miss_on_lookup |=> (lookup_set != $past(lookup_set)) ||
                           (victim_way == $past(next_victim_way)));

    assert_replaced_not_next_R9: assert property (@(posedge clk) disable iff (rst)
        miss_on_lookup |=> (lookup_set != $past(lookup_set)) ||
                           (next_victim_way != $past(victim_way)));

    assert_hit_victim_promotes_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_on_lookup && hit_way == victim_way) |=>
            (lookup_set != $past(lookup_set)) ||
            (victim_way == $past(next_victim_way) && next_victim_way != $past(hit_way)));

    assert_hit_next_keeps_victim_R6: assert property (@(posedge clk) disable iff (rst)
        (hit_on_lookup && hit_way == next_victim_way) |=>
            (lookup_set != $past(lookup_set)) ||
            (victim_way == $past(victim_way) && next_victim_way != $past(hit_way)));

    assert_hit_ordinary_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_on_lookup && hit_way != victim_way && hit_way != next_victim_way) |=>
            (lookup_set != $past(lookup_set)) ||
            ($stable(victim_way) && $stable(next_victim_way)));

    assert_miss_wins_same_set_R8: assert property (@(posedge clk) disable iff (rst)
        (miss_on_lookup && hit_valid && hit_set == miss_set && hit_way == next_victim_way) |=>
            (lookup_set != $past(lookup_set)) ||
            (victim_way == $past(next_victim_way)));
endmodule

bind vnv_repl_tracker vnv_tracker_checker #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS)
) u_checker (.*);

// File: tb/vnv_repl_tracker_test.sv
`timescale 1ns/1ps
module vnv_repl_tracker_test;
    localparam int NS = 16;
    localparam int NW = 4;
    localparam int SW = $clog2(NS);
    localparam int WW = $clog2(NW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_valid = 1'b0;
    logic [SW-1:0] hit_set = '0;
    logic [WW-1:0] hit_way = '0;
    logic miss_valid = 1'b0;
    logic [SW-1:0] miss_set = '0;
    logic [WW-1:0] miss_victim;
    logic [SW-1:0] lookup_set = '0;
    logic [WW-1:0] victim_way;
    logic [WW-1:0] next_victim_way;

    always #2.5 clk = ~clk;

    vnv_repl_tracker #(.NUM_SETS(NS), .NUM_WAYS(NW)) uut (
        .clk(clk), .rst(rst),
        .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
        .miss_valid(miss_valid), .miss_set(miss_set), .miss_victim(miss_victim),
        .lookup_set(lookup_set), .victim_way(victim_way), .next_victim_way(next_victim_way)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int ev_v  [NS];
    int ev_nv [NS];
    logic [7:0] m_reg;

    function automatic int m_pick(int v, int nv, logic [7:0] r);
        int c;
        c = int'(r) % NW;
        while (c == v || c == nv) c = (c + 1) % NW;
        return c;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_set(string req, int s);
        lookup_set = SW'(s);
        #0.2;
        check(req, int'(victim_way), ev_v[s]);
        check(req, int'(next_victim_way), ev_nv[s]);
    endtask

    // One cycle: drive just after an edge, sample miss_victim before the next edge,
    // update the model at that edge.
    task automatic apply(bit h, int hs, int hw, bit m, int ms);
        bit upd;
        int p;
        hit_valid = h; hit_set = SW'(hs); hit_way = WW'(hw);
        miss_valid = m; miss_set = SW'(ms);
        #0.2;
        if (m) check("R3 miss_victim", int'(miss_victim), ev_v[ms]);
        upd = 0;
        if (m) begin
            p = m_pick(ev_v[ms], ev_nv[ms], m_reg);
            ev_v[ms] = ev_nv[ms]; ev_nv[ms] = p; upd = 1;
        end
        if (h && !(m && hs == ms)) begin
            if (hw == ev_v[hs]) begin
                p = m_pick(ev_v[hs], ev_nv[hs], m_reg);
                ev_v[hs] = ev_nv[hs]; ev_nv[hs] = p; upd = 1;
            end else if (hw == ev_nv[hs]) begin
                ev_nv[hs] = m_pick(ev_v[hs], ev_nv[hs], m_reg); upd = 1;
            end
        end
        if (upd) m_reg = {m_reg[6:0], m_reg[7] ^ m_reg[5] ^ m_reg[4] ^ m_reg[3]};
        @(posedge clk); #1;
        hit_valid = 0; miss_valid = 0;
    endtask

    task automatic t_reset;
        for (int s = 0; s < NS; s++) check_set("R1 reset", s);
    endtask

    task automatic t_misses;
        for (int i = 0; i < 6; i++) begin
            int ov;
            int onv;
            ov = ev_v[3]; onv = ev_nv[3];
            apply(0, 0, 0, 1, 3);
            check_set("R3/R4 miss", 3);
            check("R3 victim from next", int'(victim_way), onv);
            checks++;
            if (next_victim_way == WW'(ov)) begin
                errors++;
                $display("FAIL R9: actual=%0d expected!=%0d", next_victim_way, ov);
            end
        end
    endtask

    task automatic t_hit_victim;
        apply(1, 5, ev_v[5], 0, 0);
        check_set("R5 hit victim", 5);
        apply(1, 5, ev_v[5], 0, 0);
        check_set("R5 hit victim again", 5);
    endtask

    task automatic t_hit_next;
        int ov;
        ov = ev_v[6];
        apply(1, 6, ev_nv[6], 0, 0);
        check_set("R6 hit next", 6);
        check("R6 victim kept", int'(victim_way), ov);
    endtask

    task automatic t_hit_ordinary;
        int w;
        w = 0;
        while (w == ev_v[7] || w == ev_nv[7]) w++;
        apply(1, 7, w, 0, 0);
        check_set("R7 hit ordinary", 7);
        apply(0, 0, 0, 1, 8);  // pick reveals whether the register moved
        check_set("R7 register held", 8);
    endtask

    task automatic t_same_set;
        apply(1, 9, ev_nv[9], 1, 9);
        check_set("R8 miss wins", 9);
    endtask

    task automatic t_diff_sets;
        apply(1, 10, ev_v[10], 1, 11);
        check_set("R10 hit set", 10);
        check_set("R10 miss set", 11);
        apply(0, 0, 0, 1, 12);
        check_set("R10 single step", 12);
    endtask

    task automatic t_mixed;
        for (int i = 0; i < 300; i++) begin
            int s1;
            int s2;
            s1 = (i * 7 + 3) % NS;
            s2 = (i * 5 + 1) % NS;
            apply((i % 3) != 0, s1, (i * 3) % NW, (i % 4) == 1, s2);
        end
        for (int s = 0; s < NS; s++) check_set("R4 mixed run", s);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NS; s++) begin ev_v[s] = 0; ev_nv[s] = 1; end
        m_reg = 8'hA5;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_misses();
        t_hit_victim();
        t_hit_next();
        t_hit_ordinary();
        t_same_set();
        t_diff_sets();
        t_mixed();
        finish_run();
    end
endmodule